// File: doc/BRIEF.md
# Indexed Load/Store Address Unit

This block takes one decoded register-indexed memory instruction at a time and turns it into a single request on a simple memory port. It forms the effective address from a base and an index register, aligns store data into the low lanes of the write bus, and widens returned load data to a full register with zero or sign fill. For the update forms, it also returns the computed address for write-back to the base register.

The caller presents an opcode class, the 32-bit instruction word and the three register-file read values, together with the external access control register, under a valid/ready handshake. Exactly one response cycle follows each accepted instruction. In that cycle `done` pulses and reports the effective address. The load result and the base write-back appear in the same cycle on two separate write ports. Illegal-form, access-fault and alignment-fault flags are reported in that cycle as well. Cache hints compute their address and are otherwise no-ops.

Top module: `idx_lsu`

## Requirements
- R1: Destination/source index is instruction bits 25:21, base index A bits 20:16, index B bits 15:11. Non-update forms use address B when A is 0 (the value on `ra_val` is ignored), otherwise `ra_val + rb_val` modulo 2^32. The address is reported on `done_ea` in the response cycle.
- R2: Update forms (op codes 1, 3, 5, 7, 9, 11) always use `ra_val + rb_val`. After a legal access they assert `wb_valid` with `wb_idx` = A and `wb_data` = the effective address in the response cycle.
- R3: An update form with A = 0, or a load update form with A equal to the destination index, raises `flag_illegal` in the response cycle. It makes no memory request and asserts neither `ld_valid` nor `wb_valid`.
- R4: Load op codes are 0/1 byte zero-extended, 2/3 halfword zero-extended, 4/5 halfword sign-extended from bit 15, and 6/7 word. `mem_rdata` is right-aligned. The result appears on `ld_data` with `ld_idx` = destination index and `mem_size` 0/1/2 for byte/half/word.
- R5: Store op codes are 8/9 byte, 10/11 halfword and 12 word. `mem_we` is 1 and `mem_wdata` holds only the low 8, 16 or 32 bits of `rs_val`, with the upper bits zero.
- R6: Op code 13 (external word load) and op code 14 (external word store) proceed only when `ext_ctl` bit 31 is 1. Otherwise `flag_access` is raised and there is no memory request and no register write.
- R7: Op code 14 with either of the two low address bits nonzero raises `flag_align` and makes no memory request. Op code 13 has no alignment check. An access fault takes precedence over an alignment fault.
- R8: Op code 15 (cache touch, touch-for-store, invalidate) computes the address like R1 but makes no memory request and no register write.
- R9: `req_ready` is high only when idle. After an accepting edge, a memory request is presented in the next cycle and is held with stable address and data until `mem_ack`. The response cycle follows the acknowledging edge, and `req_ready` returns in the cycle after that. Instructions without a memory access respond in the cycle after acceptance.
- R10: A load update presents `ld_valid` and `wb_valid` in the same response cycle, on different register indices.
- R11: During and after reset, `req_ready` is 1 and `mem_valid`, `done`, `ld_valid`, `wb_valid` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction offered |
| req_ready | output | 1 | Unit idle, instruction accepted on this edge |
| req_op | input | 4 | Opcode class |
| req_instr | input | 32 | Instruction word carrying register fields |
| ra_val | input | 32 | Base register value |
| rb_val | input | 32 | Index register value |
| rs_val | input | 32 | Store source register value |
| ext_ctl | input | 32 | External access control register |
| mem_valid | output | 1 | Memory request pending |
| mem_ack | input | 1 | Memory completes the request |
| mem_addr | output | 32 | Request address |
| mem_size | output | 2 | 0 byte, 1 half, 2 word |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_rdata | input | 32 | Right-aligned read data, valid with ack |
| ld_valid | output | 1 | Load result write port valid |
| ld_idx | output | 5 | Load destination register |
| ld_data | output | 32 | Extended load result |
| wb_valid | output | 1 | Base write-back port valid |
| wb_idx | output | 5 | Base register index |
| wb_data | output | 32 | Updated base value |
| done | output | 1 | Response cycle of an instruction |
| done_ea | output | 32 | Effective address of that instruction |
| flag_illegal | output | 1 | Illegal update form |
| flag_access | output | 1 | External access disabled |
| flag_align | output | 1 | Misaligned external store |

## Verification
A corrupted captured decode shows up in the first cycle after acceptance, as a wrong address, size, write enable or wrongly present request on the memory port. A wrong sequencer state shows as an early or missing `mem_valid`, a request that drifts during a stall, or `req_ready` not returning one cycle after the response. Errors in load widening or fault classification appear in the single response cycle on `ld_data`, the write-back port or the flags. The bench samples every one of these at that exact cycle.

// File: rtl/idx_lsu_pkg.sv
package idx_lsu_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned FLD_D  = 21;
  localparam int unsigned FLD_A  = 16;
  localparam int unsigned FLD_B  = 11;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [3:0] {
    OPC_LD_B, OPC_LD_B_UPD, OPC_LD_H, OPC_LD_H_UPD,
    OPC_LD_HS, OPC_LD_HS_UPD, OPC_LD_W, OPC_LD_W_UPD,
    OPC_ST_B, OPC_ST_B_UPD, OPC_ST_H, OPC_ST_H_UPD,
    OPC_ST_W, OPC_EXT_LD, OPC_EXT_ST, OPC_HINT
  } lsu_op_e;

  typedef enum logic [1:0] { LK_ZB, LK_ZH, LK_SH, LK_W } ld_kind_e;

  typedef struct packed {
    logic [XLEN-1:0]   ea;
    logic [XLEN-1:0]   wdata;
    logic [1:0]        size;
    ld_kind_e          kind;
    logic              is_load;
    logic              is_upd;
    logic              go_mem;
    logic              f_ill;
    logic              f_acc;
    logic              f_aln;
    logic [RIDX_W-1:0] d_idx;
    logic [RIDX_W-1:0] a_idx;
  } dec_t;

  function automatic logic [XLEN-1:0] eff_addr(input logic [RIDX_W-1:0] a_idx,
                                               input logic [XLEN-1:0] a_val,
                                               input logic [XLEN-1:0] b_val,
                                               input logic upd);
    logic [XLEN-1:0] sum;
    sum = a_val + b_val;
    return (!upd && a_idx == '0) ? b_val : sum;
  endfunction

  function automatic logic [XLEN-1:0] fit_load(input ld_kind_e k, input logic [XLEN-1:0] d);
    logic [XLEN-1:0] r;
    case (k)
      LK_ZB:   r = {{(XLEN-8){1'b0}}, d[7:0]};
      LK_ZH:   r = {{(XLEN-16){1'b0}}, d[15:0]};
      LK_SH:   r = {{(XLEN-16){d[15]}}, d[15:0]};
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] fit_store(input logic [1:0] sz, input logic [XLEN-1:0] d);
    logic [XLEN-1:0] r;
    case (sz)
      SZ_BYTE: r = {{(XLEN-8){1'b0}}, d[7:0]};
      SZ_HALF: r = {{(XLEN-16){1'b0}}, d[15:0]};
      default: r = d;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/idx_lsu_decode.sv
module idx_lsu_decode
  import idx_lsu_pkg::*;
(
  input  lsu_op_e         op_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] a_val_i,
  input  logic [XLEN-1:0] b_val_i,
  input  logic [XLEN-1:0] s_val_i,
  input  logic            ext_en_i,
  output dec_t            dec_o
);
  logic [RIDX_W-1:0] d_idx, a_idx;
  logic [1:0]        size;
  ld_kind_e          kind;
  logic              upd, is_load, is_ext, is_hint;
  logic [XLEN-1:0]   ea;
  logic              unused_fmt;

  assign d_idx = instr_i[FLD_D +: RIDX_W];
  assign a_idx = instr_i[FLD_A +: RIDX_W];
  assign unused_fmt = ^{instr_i[XLEN-1:FLD_D+RIDX_W], instr_i[FLD_A-1:FLD_B], instr_i[FLD_B-1:0]};

  always_comb begin
    upd = 1'b0; is_load = 1'b0; is_ext = 1'b0; is_hint = 1'b0;
    size = SZ_WORD; kind = LK_W;
    case (op_i)
      OPC_LD_B, OPC_LD_B_UPD:   begin is_load = 1'b1; size = SZ_BYTE; kind = LK_ZB; end
      OPC_LD_H, OPC_LD_H_UPD:   begin is_load = 1'b1; size = SZ_HALF; kind = LK_ZH; end
      OPC_LD_HS, OPC_LD_HS_UPD: begin is_load = 1'b1; size = SZ_HALF; kind = LK_SH; end
      OPC_LD_W, OPC_LD_W_UPD:   begin is_load = 1'b1; end
      OPC_ST_B, OPC_ST_B_UPD:   size = SZ_BYTE;
      OPC_ST_H, OPC_ST_H_UPD:   size = SZ_HALF;
      OPC_ST_W:                 size = SZ_WORD;
      OPC_EXT_LD:               begin is_load = 1'b1; is_ext = 1'b1; end
      OPC_EXT_ST:               is_ext = 1'b1;
      default:                  is_hint = 1'b1;
    endcase
    upd = op_i inside {OPC_LD_B_UPD, OPC_LD_H_UPD, OPC_LD_HS_UPD, OPC_LD_W_UPD,
                       OPC_ST_B_UPD, OPC_ST_H_UPD};
  end

  assign ea = eff_addr(a_idx, a_val_i, b_val_i, upd);

  always_comb begin
    dec_o         = '0;
    dec_o.ea      = ea;
    dec_o.wdata   = fit_store(size, s_val_i);
    dec_o.size    = size;
    dec_o.kind    = kind;
    dec_o.is_load = is_load;
    dec_o.is_upd  = upd;
    dec_o.d_idx   = d_idx;
    dec_o.a_idx   = a_idx;
    dec_o.f_ill   = upd && (a_idx == '0 || (is_load && a_idx == d_idx));
    dec_o.f_acc   = is_ext && !ext_en_i;
    dec_o.f_aln   = (op_i == OPC_EXT_ST) && ext_en_i && (ea[1:0] != 2'b00);
    dec_o.go_mem  = !is_hint && !dec_o.f_ill && !dec_o.f_acc && !dec_o.f_aln;
  end
endmodule

// File: rtl/idx_lsu_shape.sv
module idx_lsu_shape
  import idx_lsu_pkg::*;
(
  input  ld_kind_e        kind_i,
  input  logic [XLEN-1:0] raw_i,
  output logic [XLEN-1:0] res_o
);
  assign res_o = fit_load(kind_i, raw_i);
endmodule

// File: rtl/idx_lsu.sv
module idx_lsu
  import idx_lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [XLEN-1:0]   req_instr,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   rb_val,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   ext_ctl,
  output logic              mem_valid,
  input  logic              mem_ack,
  output logic [XLEN-1:0]   mem_addr,
  output logic [1:0]        mem_size,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              ld_valid,
  output logic [RIDX_W-1:0] ld_idx,
  output logic [XLEN-1:0]   ld_data,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data,
  output logic              done,
  output logic [XLEN-1:0]   done_ea,
  output logic              flag_illegal,
  output logic              flag_access,
  output logic              flag_align
);
  typedef enum logic [1:0] { SQ_IDLE, SQ_MEM, SQ_RSP } seq_e;

  seq_e            st_q;
  dec_t            dec_c, dec_q;
  logic [XLEN-1:0] ld_c, ld_q;
  logic            accept_evt, mem_fire, rsp_evt;
  logic            unused_ctl;

  assign unused_ctl = ^ext_ctl[XLEN-2:0];

  idx_lsu_decode u_dec (
    .op_i     (lsu_op_e'(req_op)),
    .instr_i  (req_instr),
    .a_val_i  (ra_val),
    .b_val_i  (rb_val),
    .s_val_i  (rs_val),
    .ext_en_i (ext_ctl[XLEN-1]),
    .dec_o    (dec_c)
  );

  idx_lsu_shape u_shp (
    .kind_i (dec_q.kind),
    .raw_i  (mem_rdata),
    .res_o  (ld_c)
  );

  // named events for the checker
  assign accept_evt = req_valid && req_ready;
  assign mem_fire   = mem_valid && mem_ack;
  assign rsp_evt    = (st_q == SQ_RSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      dec_q <= '0;
      ld_q  <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (accept_evt) begin
          dec_q <= dec_c;
          st_q  <= dec_c.go_mem ? SQ_MEM : SQ_RSP;
        end
        SQ_MEM: if (mem_ack) begin
          ld_q <= ld_c;
          st_q <= SQ_RSP;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign req_ready    = (st_q == SQ_IDLE);
  assign mem_valid    = (st_q == SQ_MEM);
  assign mem_addr     = dec_q.ea;
  assign mem_size     = dec_q.size;
  assign mem_we       = !dec_q.is_load;
  assign mem_wdata    = dec_q.wdata;

  assign done         = rsp_evt;
  assign done_ea      = dec_q.ea;
  assign ld_valid     = rsp_evt && dec_q.go_mem && dec_q.is_load;
  assign ld_idx       = dec_q.d_idx;
  assign ld_data      = ld_q;
  assign wb_valid     = rsp_evt && dec_q.go_mem && dec_q.is_upd;
  assign wb_idx       = dec_q.a_idx;
  assign wb_data      = dec_q.ea;
  assign flag_illegal = rsp_evt && dec_q.f_ill;
  assign flag_access  = rsp_evt && dec_q.f_acc;
  assign flag_align   = rsp_evt && dec_q.f_aln;
endmodule

// File: rtl/idx_lsu_chk.sv
module idx_lsu_chk
  import idx_lsu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              accept_evt,
  input logic              mem_valid,
  input logic              mem_ack,
  input logic              mem_fire,
  input logic              mem_we,
  input logic [1:0]        mem_size,
  input logic [XLEN-1:0]   mem_addr,
  input logic [XLEN-1:0]   mem_wdata,
  input logic              ld_valid,
  input logic [RIDX_W-1:0] ld_idx,
  input logic              wb_valid,
  input logic [RIDX_W-1:0] wb_idx,
  input logic              done,
  input logic              flag_illegal,
  input logic              flag_access,
  input logic              flag_align
);
  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ack |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !req_ready);

  assert_load_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire && !mem_we |=> ld_valid && done);

  assert_split_ports_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && wb_valid |-> ld_idx != wb_idx);

  assert_wb_base_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_idx != '0);

  assert_fault_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_illegal || flag_access || flag_align) |-> !ld_valid && !wb_valid && !mem_valid);

  assert_byte_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && mem_size == SZ_BYTE |-> mem_wdata[XLEN-1:8] == '0);
endmodule

bind idx_lsu idx_lsu_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .accept_evt   (accept_evt),
  .mem_valid    (mem_valid),
  .mem_ack      (mem_ack),
  .mem_fire     (mem_fire),
  .mem_we       (mem_we),
  .mem_size     (mem_size),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .ld_valid     (ld_valid),
  .ld_idx       (ld_idx),
  .wb_valid     (wb_valid),
  .wb_idx       (wb_idx),
  .done         (done),
  .flag_illegal (flag_illegal),
  .flag_access  (flag_access),
  .flag_align   (flag_align)
);

// File: tb/idx_lsu_test.sv
module idx_lsu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = '0;
  logic [31:0] req_instr = '0, ra_val = '0, rb_val = '0, rs_val = '0, ext_ctl = '0;
  logic        mem_valid, mem_ack = 1'b0, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [1:0]  mem_size;
  logic        ld_valid, wb_valid, done, flag_illegal, flag_access, flag_align;
  logic [4:0]  ld_idx, wb_idx;
  logic [31:0] ld_data, wb_data, done_ea;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  idx_lsu uut (.*);

  typedef struct packed {
    logic [3:0]  op;
    logic [4:0]  d, a, b;
    logic [31:0] ra, rb, rs, rd;
    logic        ext;
    logic [2:0]  dly;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{4'd0,  5'd3,  5'd0,  5'd4, 32'hFFFF_FFFF, 32'h0000_1000, 32'h0, 32'h1234_56A7, 1'b0, 3'd0},
    '{4'd1,  5'd6,  5'd5,  5'd7, 32'h0000_0100, 32'h0000_0023, 32'h0, 32'h0000_00FF, 1'b0, 3'd0},
    '{4'd2,  5'd8,  5'd2,  5'd9, 32'h0000_2000, 32'h0000_0004, 32'h0, 32'hDEAD_8001, 1'b0, 3'd1},
    '{4'd3,  5'd11, 5'd10, 5'd1, 32'hFFFF_FFF0, 32'h0000_0020, 32'h0, 32'h5555_1234, 1'b0, 3'd0},
    '{4'd4,  5'd12, 5'd0,  5'd13,32'h7777_7777, 32'h0000_3000, 32'h0, 32'h0000_9234, 1'b0, 3'd0},
    '{4'd5,  5'd15, 5'd14, 5'd2, 32'h0000_0040, 32'h0000_0002, 32'h0, 32'hFFFF_7FFF, 1'b0, 3'd2},
    '{4'd6,  5'd4,  5'd3,  5'd5, 32'h1000_0000, 32'h0000_0008, 32'h0, 32'hCAFE_BABE, 1'b0, 3'd2},
    '{4'd7,  5'd5,  5'd4,  5'd6, 32'h0000_0800, 32'h0000_0800, 32'h0, 32'h0BAD_F00D, 1'b0, 3'd0},
    '{4'd8,  5'd7,  5'd1,  5'd2, 32'h0000_0010, 32'h0000_0001, 32'hAABB_CCDD, 32'h0, 1'b0, 3'd0},
    '{4'd9,  5'd7,  5'd9,  5'd2, 32'h0000_0200, 32'h0000_0003, 32'h1122_3344, 32'h0, 1'b0, 3'd1},
    '{4'd10, 5'd7,  5'd0,  5'd2, 32'hFFFF_0000, 32'h0000_0402, 32'h1234_5678, 32'h0, 1'b0, 3'd0},
    '{4'd12, 5'd7,  5'd3,  5'd2, 32'h0000_0100, 32'h0000_0004, 32'h8765_4321, 32'h0, 1'b0, 3'd1}
  };

  typedef struct {
    bit          acc, we, ldv, wbv, ill, acf, alf;
    logic [31:0] ea, wd, ldd;
    logic [1:0]  sz;
  } exp_t;

  function automatic exp_t model(input int op, input int d, input int a,
                                 input logic [31:0] ra, input logic [31:0] rb,
                                 input logic [31:0] rs, input logic [31:0] rd, input bit ext);
    exp_t e;
    bit upd, ld, xo;
    logic [31:0] h;
    upd   = op inside {1, 3, 5, 7, 9, 11};
    ld    = (op < 8) || (op == 13);
    xo    = (op == 13) || (op == 14);
    e.ea  = (a != 0 || upd) ? ra + rb : rb;
    e.ill = upd && ((a == 0) || (ld && a == d));
    e.acf = xo && !ext;
    e.alf = (op == 14) && ext && (e.ea % 4 != 0);
    e.acc = !(e.ill || e.acf || e.alf) && (op != 15);
    e.we  = !ld;
    if (op inside {0, 1, 8, 9}) e.sz = 2'd0;
    else if (op inside {2, 3, 4, 5, 10, 11}) e.sz = 2'd1;
    else e.sz = 2'd2;
    e.wd  = (e.sz == 0) ? rs % 256 : (e.sz == 1) ? rs % 65536 : rs;
    h     = rd % 65536;
    if (op < 2) e.ldd = rd % 256;
    else if (op < 4) e.ldd = h;
    else if (op < 6) e.ldd = (h >= 32768) ? h + 32'hFFFF_0000 : h;
    else e.ldd = rd;
    e.ldv = e.acc && ld;
    e.wbv = e.acc && upd;
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [4:0] d, input logic [4:0] a,
                     input logic [4:0] b, input logic [31:0] ra, input logic [31:0] rb,
                     input logic [31:0] rs, input logic [31:0] rd, input bit ext, input int dly);
    exp_t e;
    bit   saw;
    logic [31:0] cap_addr;
    string tq;
    e  = model(int'(op), int'(d), int'(a), ra, rb, rs, rd, ext);
    tq = (op == 4'd15) ? "R8" : (e.ill ? "R3" : (e.acf ? "R6" : (e.alf ? "R7" : "R9")));
    @(negedge clk);
    chk("R9", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_op = op;
    req_instr = {6'd31, d, a, b, 11'd0};
    ra_val = ra; rb_val = rb; rs_val = rs;
    ext_ctl = ext ? 32'h8000_0000 : 32'h7FFF_FFFF;
    @(negedge clk);
    req_valid = 1'b0; req_op = 4'd0; ra_val = '0; rb_val = '0; rs_val = '0;
    saw = mem_valid;
    chk(tq, 32'(saw), 32'(e.acc));
    if (saw) begin
      cap_addr = mem_addr;
      chk("R1", mem_addr, e.ea);
      chk(e.we ? "R5" : "R4", 32'(mem_size), 32'(e.sz));
      chk("R5", 32'(mem_we), 32'(e.we));
      if (e.we) chk("R5", mem_wdata, e.wd);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk("R9", 32'(mem_valid), 32'd1);
        chk("R9", mem_addr, cap_addr);
        chk("R9", 32'(done), 32'd0);
      end
      mem_ack = 1'b1; mem_rdata = rd;
      @(negedge clk);
      mem_ack = 1'b0; mem_rdata = 32'h0;
    end
    chk("R9", 32'(done), 32'd1);
    chk("R1", done_ea, e.ea);
    chk("R4", 32'(ld_valid), 32'(e.ldv));
    if (e.ldv) begin
      chk(e.wbv ? "R10" : "R4", 32'(ld_idx), 32'(d));
      chk("R4", ld_data, e.ldd);
    end
    chk("R2", 32'(wb_valid), 32'(e.wbv));
    if (e.wbv) begin
      chk("R2", 32'(wb_idx), 32'(a));
      chk("R2", wb_data, e.ea);
    end
    chk("R3", 32'(flag_illegal), 32'(e.ill));
    chk("R6", 32'(flag_access), 32'(e.acf));
    chk("R7", 32'(flag_align), 32'(e.alf));
    @(negedge clk);
    chk("R9", 32'(req_ready), 32'd1);
    chk("R9", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", 32'(req_ready), 32'd1);
    chk("R11", 32'(mem_valid), 32'd0);
    chk("R11", 32'(done), 32'd0);
    chk("R11", 32'({ld_valid, wb_valid, flag_illegal, flag_access, flag_align}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", 32'(req_ready), 32'd1);

    foreach (VECS[i])
      run(VECS[i].op, VECS[i].d, VECS[i].a, VECS[i].b, VECS[i].ra, VECS[i].rb,
          VECS[i].rs, VECS[i].rd, VECS[i].ext, int'(VECS[i].dly));

    // R6 external ops gated by control bit 31
    run(4'd13, 5'd2, 5'd1, 5'd3, 32'h100, 32'h4, 32'h0, 32'h89AB_CDEF, 1'b0, 0);
    run(4'd13, 5'd2, 5'd1, 5'd3, 32'h100, 32'h5, 32'h0, 32'h89AB_CDEF, 1'b1, 1);
    run(4'd14, 5'd2, 5'd0, 5'd3, 32'h0,   32'h40, 32'h0102_0304, 32'h0, 1'b0, 0);
    run(4'd14, 5'd2, 5'd0, 5'd3, 32'h0,   32'h40, 32'h0102_0304, 32'h0, 1'b1, 0);
    // R7 misaligned external store, and access fault winning over it
    run(4'd14, 5'd2, 5'd6, 5'd3, 32'h100, 32'h2, 32'h0102_0304, 32'h0, 1'b1, 0);
    run(4'd14, 5'd2, 5'd6, 5'd3, 32'h100, 32'h1, 32'h0102_0304, 32'h0, 1'b0, 0);
    // R3 illegal update forms
    run(4'd5,  5'd9, 5'd9, 5'd3, 32'h100, 32'h2, 32'h0, 32'h8000, 1'b0, 0);
    run(4'd5,  5'd9, 5'd0, 5'd3, 32'h100, 32'h2, 32'h0, 32'h8000, 1'b0, 0);
    run(4'd11, 5'd4, 5'd0, 5'd3, 32'h100, 32'h2, 32'hFFFF, 32'h0, 1'b0, 0);
    run(4'd1,  5'd7, 5'd7, 5'd3, 32'h100, 32'h2, 32'h0, 32'h12, 1'b0, 0);
    // R8 hints with zero and nonzero base
    run(4'd15, 5'd0, 5'd0, 5'd3, 32'hFFFF_FFFF, 32'h0000_5000, 32'h0, 32'h0, 1'b1, 0);
    run(4'd15, 5'd0, 5'd8, 5'd3, 32'h0000_1000, 32'h0000_5000, 32'h0, 32'h0, 1'b1, 0);
    // R9 long stall, R10 both write ports
    run(4'd7,  5'd20, 5'd21, 5'd3, 32'hFFFF_FFFC, 32'h8, 32'h0, 32'h7654_3210, 1'b0, 5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule